// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds two unsigned operands one bit per clock. Operand A sits in an accumulator register that is one bit wider than the operands. Operand B sits in a shift register of operand width. A pulse on `start` clears a single carry flip-flop. Both registers then shift right, so the least significant bits reach one full adder first. Each sum bit enters the top of the accumulator's operand-width field. After the last data bit, one more clock writes the final carry into the extra top bit. The complete sum, including its carry, is then in the accumulator.

The B register rotates its bits back in as they leave, so B is intact after every add. A further `start` without a new load adds B again to the low part of the accumulator. This makes the block a running accumulator. Operands enter through a parallel load strobe, and the result is always visible on a parallel port. `busy` and a one-cycle `done` pulse mark the progress of an add.

Top module: `bitser_accum_adder`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `result` is all zeros.
- R2: When `load` is high and `busy` is low, `result` shows `{1'b0, op_a}` from the next cycle. While idle and with `load` low, `result` holds its value.
- R3: When `done` is high, `result` equals the (OP_W+1)-bit sum of the accumulator's low OP_W bits and operand B. Bit OP_W of `result` is the carry out.
- R4: `busy` rises in the cycle after `start` is sampled with `busy` low. It stays high for exactly OP_W+1 cycles: OP_W data bits plus one cycle for the carry.
- R5: `done` is high for exactly one cycle, in the first cycle in which `busy` is low again.
- R6: A `load` while `busy` is high changes neither the accumulator nor operand B.
- R7: A `start` while `busy` is high neither restarts nor extends the running add, and it produces no second `done`.
- R8: Operand B is kept after an add. A further `start` without a load adds B to the accumulator's low OP_W bits, and the old top bit is discarded.
- R9: The carry flip-flop is cleared on `start`, so a carry left over from the previous add never enters the next one.
- R10: When `load` and `start` are high in the same idle cycle, the add uses the newly loaded operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Parallel load strobe for both operands (honoured only while idle) |
| op_a | input | OP_W | Operand placed in the accumulator |
| op_b | input | OP_W | Operand placed in the B shift register |
| start | input | 1 | Starts an add (honoured only while idle) |
| busy | output | 1 | High while an add is in progress |
| done | output | 1 | One-cycle pulse when an add completes |
| result | output | OP_W+1 | Accumulator contents |

## Verification
The adder is tried with:
- small directed pairs;
- zero plus zero;
- all-ones plus all-ones, which propagates a carry through every bit and sets the top bit;
- a maximum-plus-one pair, which produces a carry with all-zero low bits;
- a batch of random operands.

Repeated `start` without a reload separates a rotating B register from one that empties, and it separates correct top-bit handling from a stale one. A zero add placed right after an all-ones add shows whether the carry is cleared. Loads and starts driven in the middle of an add, and a load driven together with a start, test the handshake rules.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_CARRY = 2'd2
  } bsa_state_e;

endpackage

// File: rtl/bsa_ctrl.sv
module bsa_ctrl
  import bsa_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic shift_en_o,
  output logic carry_wr_o,
  output logic clear_o,
  output logic busy_o,
  output logic done_o
);

  localparam int CNT_W = (OP_W > 1) ? $clog2(OP_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(OP_W - 1);

  bsa_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_SHIFT;
          cnt_d   = '0;
        end
      end
      ST_SHIFT: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_BIT) begin
          state_d = ST_CARRY;
        end
      end
      ST_CARRY: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign shift_en_o = (state_q == ST_SHIFT);
  assign carry_wr_o = (state_q == ST_CARRY);
  assign clear_o    = (state_q == ST_IDLE) && start_i;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;

endmodule

// File: rtl/bsa_bit_alu.sv
module bsa_bit_alu (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic step_i,
  input  logic a_i,
  input  logic b_i,
  output logic sum_o,
  output logic carry_o
);

  logic carry_q, carry_d;
  logic cout;

  assign sum_o = a_i ^ b_i ^ carry_q;
  assign cout  = (a_i & b_i) | (a_i & carry_q) | (b_i & carry_q);

  always_comb begin
    carry_d = carry_q;
    if (clear_i) begin
      carry_d = 1'b0;
    end else if (step_i) begin
      carry_d = cout;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
    end else begin
      carry_q <= carry_d;
    end
  end

  assign carry_o = carry_q;

endmodule

// File: rtl/bsa_oper_sreg.sv
module bsa_oper_sreg #(
  parameter int OP_W         = 8,
  parameter bit KEEP_OPERAND = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [OP_W-1:0] val_i,
  input  logic            shift_i,
  output logic            lsb_o
);

  logic [OP_W-1:0] op_q, op_d;
  logic            fill;

  generate
    if (KEEP_OPERAND) begin : g_rotate
      assign fill = op_q[0];
    end else begin : g_drain
      assign fill = 1'b0;
    end
  endgenerate

  always_comb begin
    op_d = op_q;
    if (load_i) begin
      op_d = val_i;
    end else if (shift_i) begin
      op_d = {fill, op_q[OP_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0;
    end else begin
      op_q <= op_d;
    end
  end

  assign lsb_o = op_q[0];

endmodule

// File: rtl/bsa_accum_sreg.sv
module bsa_accum_sreg #(
  parameter int OP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [OP_W-1:0] val_i,
  input  logic            shift_i,
  input  logic            sum_i,
  input  logic            carry_wr_i,
  input  logic            carry_i,
  output logic            lsb_o,
  output logic [OP_W:0]   value_o
);

  logic [OP_W:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (load_i) begin
      acc_d = {1'b0, val_i};
    end else if (shift_i) begin
      acc_d[OP_W-1:0] = {sum_i, acc_q[OP_W-1:1]};
    end else if (carry_wr_i) begin
      acc_d[OP_W] = carry_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign lsb_o   = acc_q[0];
  assign value_o = acc_q;

endmodule

// File: rtl/bitser_accum_adder.sv
module bitser_accum_adder #(
  parameter int OP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [OP_W-1:0] op_a,
  input  logic [OP_W-1:0] op_b,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic [OP_W:0]   result
);

  logic shift_en, carry_wr, clear_c;
  logic load_en;
  logic a_bit, b_bit, sum_bit, carry_bit;

  assign load_en = load & ~busy;

  bsa_ctrl #(.OP_W(OP_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .shift_en_o (shift_en),
    .carry_wr_o (carry_wr),
    .clear_o    (clear_c),
    .busy_o     (busy),
    .done_o     (done)
  );

  bsa_bit_alu u_alu (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (clear_c),
    .step_i  (shift_en),
    .a_i     (a_bit),
    .b_i     (b_bit),
    .sum_o   (sum_bit),
    .carry_o (carry_bit)
  );

  bsa_oper_sreg #(.OP_W(OP_W), .KEEP_OPERAND(1'b1)) u_opb (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_en),
    .val_i   (op_b),
    .shift_i (shift_en),
    .lsb_o   (b_bit)
  );

  bsa_accum_sreg #(.OP_W(OP_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_en),
    .val_i      (op_a),
    .shift_i    (shift_en),
    .sum_i      (sum_bit),
    .carry_wr_i (carry_wr),
    .carry_i    (carry_bit),
    .lsb_o      (a_bit),
    .value_o    (result)
  );

endmodule

// File: rtl/bsa_checker.sv
module bsa_checker #(
  parameter int OP_W = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [OP_W:0] result
);

  localparam int BC_W = $clog2(OP_W + 3) + 1;
  localparam logic [BC_W-1:0] RUN_LEN = BC_W'(OP_W + 1);

  logic [BC_W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (busy) begin
      busy_cnt <= busy_cnt + 1'b1;
    end else begin
      busy_cnt <= '0;
    end
  end

  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R4
  run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_cnt == RUN_LEN));

  // R7
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_cnt <= RUN_LEN));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load && !done) |=> $stable(result) || busy);

  // R3
  top_bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(result[OP_W]));

endmodule

bind bitser_accum_adder bsa_checker #(.OP_W(OP_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .load   (load),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .result (result)
);

// File: tb/bitser_accum_adder_test.sv
module bitser_accum_adder_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic         load;
  logic [W-1:0] op_a;
  logic [W-1:0] op_b;
  logic         start;
  logic         busy;
  logic         done;
  logic [W:0]   result;

  int checks;
  int failures;

  bitser_accum_adder #(.OP_W(W)) uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .op_a   (op_a),
    .op_b   (op_b),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input bit ok,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // All tasks start and end at a falling edge.
  task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
    load = 1'b1; op_a = a; op_b = b;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    if (!done) begin
      check("watchdog done", 1'b0, 0, 1);
    end
  endtask

  task automatic run_add(output int lat);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R4 busy after start", busy == 1'b1, busy, 1);
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    if (!done) begin
      check("watchdog done", 1'b0, 0, 1);
    end
  endtask

  task automatic t_reset();
    check("R1 busy reset", busy == 1'b0, busy, 0);
    check("R1 done reset", done == 1'b0, done, 0);
    check("R1 result reset", result == '0, result, 0);
  endtask

  task automatic t_add(input logic [W-1:0] a, input logic [W-1:0] b);
    int lat;
    logic [W:0] exp;
    exp = {1'b0, a} + {1'b0, b};
    do_load(a, b);
    check("R2 load shows A", result == {1'b0, a}, result, {1'b0, a});
    run_add(lat);
    check("R4 latency", lat == W + 1, lat, W + 1);
    check("R5 busy low at done", busy == 1'b0, busy, 0);
    check("R3 sum", result == exp, result, exp);
    @(negedge clk);
    check("R5 done one cycle", done == 1'b0, done, 0);
  endtask

  task automatic t_accumulate();
    int lat;
    logic [W:0] s1, s2;
    s1 = {1'b0, 8'hC3} + {1'b0, 8'h5A};
    s2 = {1'b0, s1[W-1:0]} + {1'b0, 8'h5A};
    t_add(8'hC3, 8'h5A);
    run_add(lat);
    check("R8 accumulate B again", result == s2, result, s2);
    @(negedge clk);
  endtask

  task automatic t_stale_carry();
    int lat;
    t_add(8'hFF, 8'hFF);
    do_load(8'h00, 8'h00);
    run_add(lat);
    check("R9 carry cleared", result == '0, result, 0);
    @(negedge clk);
  endtask

  task automatic t_load_busy();
    int lat;
    logic [W:0] s1, s2;
    s1 = {1'b0, 8'h37} + {1'b0, 8'h29};
    s2 = {1'b0, s1[W-1:0]} + {1'b0, 8'h29};
    do_load(8'h37, 8'h29);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    load = 1'b1; op_a = 8'hAA; op_b = 8'hEE;
    @(negedge clk);
    @(negedge clk);
    load = 1'b0;
    wait_done(lat);
    check("R6 load ignored acc", result == s1, result, s1);
    @(negedge clk);
    check("R6 no load after done", result == s1, result, s1);
    run_add(lat);
    check("R6 load ignored B", result == s2, result, s2);
    @(negedge clk);
  endtask

  task automatic t_start_busy();
    int lat;
    bit second_done;
    logic [W:0] s1;
    s1 = {1'b0, 8'h81} + {1'b0, 8'h7F};
    do_load(8'h81, 8'h7F);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    @(negedge clk); lat++;
    @(negedge clk); lat++;
    start = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check("R7 latency unchanged", lat == W + 1, lat, W + 1);
    check("R7 sum", result == s1, result, s1);
    second_done = 1'b0;
    for (int i = 0; i < W + 3; i++) begin
      @(negedge clk);
      if (done || busy) second_done = 1'b1;
    end
    check("R7 no restart", second_done == 1'b0, second_done, 0);
    check("R7 result held", result == s1, result, s1);
  endtask

  task automatic t_load_start_same();
    int lat;
    logic [W:0] s1;
    s1 = {1'b0, 8'h12} + {1'b0, 8'hF0};
    load = 1'b1; op_a = 8'h12; op_b = 8'hF0; start = 1'b1;
    @(negedge clk);
    load = 1'b0; start = 1'b0;
    wait_done(lat);
    check("R10 fresh operands", result == s1, result, s1);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    check("watchdog", 1'b0, 0, 1);
    finish_run();
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; load = 1'b0; start = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add(8'd3, 8'd5);
    t_add(8'd0, 8'd0);
    t_add(8'hFF, 8'hFF);
    t_add(8'hFF, 8'h01);
    for (int i = 0; i < 20; i++) begin
      t_add(W'($urandom), W'($urandom));
    end
    t_accumulate();
    t_stale_carry();
    t_load_busy();
    t_start_busy();
    t_load_start_same();
    finish_run();
  end

endmodule